// File: doc/BRIEF.md
# Banked Scratchpad Conflict Arbiter

This block sits in front of a 32-bank on-chip scratchpad whose banks each hold 32-bit words. A vector load arrives with one word address and one enable bit per lane. On acceptance the block works out how many serialized passes the load needs: lanes in different banks share a pass, lanes reading the same word share a pass by broadcast, and only distinct words in the same bank force extra passes. The block reports that count, then issues the passes one per clock. Each pass carries a per-bank row address, a per-bank enable and the mask of lanes it serves.

A mode input selects how addresses spread across banks. In narrow mode consecutive 32-bit words go to consecutive banks. In wide mode consecutive 64-bit words go to consecutive banks, so the two halves of one 64-bit word share a bank row and never conflict. While passes remain, the request side reports not ready and ignores new loads.

Top module: `bank_conflict_arb`

## Requirements
- R1: After a synchronous reset, and after a reset that cuts a load short, `req_ready` is 1 and `acc_valid`, `pass_valid`, `pass_last` and `pass_grant` are all 0.
- R2: In narrow mode (`wide_mode`=0) a lane address A maps to bank A[4:0] and row A[15:5].
- R3: In wide mode (`wide_mode`=1) the 64-bit word index K=A>>1 maps to bank K[4:0] and row K[15:5]. A granted lane's bank shows `pass_bank_en` set and row field (11 bits at bank×11 in `pass_bank_row`) equal to that row.
- R4: Lanes that fall in different banks, including at an unaligned base, are all served in one pass.
- R5: Lanes that read the same word are served together in one pass by broadcast, in either mode.
- R6: In wide mode, lanes reading the two 32-bit halves of one 64-bit word do not conflict.
- R7: On the cycle after a load is accepted, `acc_valid` is 1 and `acc_passes` equals the largest number of distinct words that active lanes demand from any one bank. The first pass appears one cycle later.
- R8: Passes appear on consecutive cycles, exactly `acc_passes` of them, with `pass_last` only on the final one. Each active lane is granted exactly once, and inactive lanes are never granted.
- R9: In each pass, every bank serves the word of its lowest-numbered pending lane, together with every pending lane that reads that same word.
- R10: `req_ready` is 0 from the cycle `acc_valid` reports a nonzero count until the `pass_last` cycle, when it returns to 1. Loads presented meanwhile are ignored and do not disturb the passes in flight.
- R11: A load with no active lanes reports `acc_passes`=0, issues no pass and leaves `req_ready` at 1.
- R12: In narrow mode, lanes with addresses base+lane×s for any odd stride s need one pass, for any subset of active lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Load request present |
| req_ready | output | 1 | Block can accept a load this cycle |
| wide_mode | input | 1 | 0: 32-bit bank interleave, 1: 64-bit bank interleave |
| req_active | input | 32 | Per-lane enable |
| req_addr | input | 512 | Per-lane 16-bit word address, lane i at bits [16i+15:16i] |
| acc_valid | output | 1 | One-cycle pulse after acceptance |
| acc_passes | output | 6 | Number of passes the accepted load needs |
| pass_valid | output | 1 | A pass is presented this cycle |
| pass_last | output | 1 | This pass is the final one |
| pass_grant | output | 32 | Lanes served by this pass |
| pass_bank_en | output | 32 | Banks read in this pass |
| pass_bank_row | output | 352 | Per-bank 11-bit row, bank b at bits [11b+10:11b] |

## Verification
The assertions take for granted that the block starts from a reset and that `req_valid`, `req_active`, `req_addr` and `wide_mode` matter only on the edge where `req_ready` is 1. Under those conditions the pass counter in the checker can pair every `acc_valid` with the run of passes that follows it. The stimulus changes inputs only on falling edges and raises `req_valid` while busy only on purpose, to show it is ignored. It always drops `req_valid` on the `pass_last` cycle, so no load is accepted by accident.

// File: rtl/bca_pkg.sv
package bca_pkg;
  localparam int unsigned BCA_LANES = 32;
  localparam int unsigned BCA_BANKS = 32;
  localparam int unsigned BCA_AW    = 16;

  typedef enum logic {
    MAP_NARROW = 1'b0,
    MAP_WIDE   = 1'b1
  } map_mode_e;
endpackage

// File: rtl/bca_pass_count.sv
module bca_pass_count #(
  parameter int unsigned LANES = 32,
  parameter int unsigned BANKS = 32,
  parameter int unsigned AW    = 16,
  localparam int unsigned BW   = $clog2(BANKS),
  localparam int unsigned CW   = $clog2(LANES + 1)
) (
  input  logic [LANES-1:0]         active,
  input  logic [LANES-1:0][AW-1:0] keys,
  output logic [CW-1:0]            passes
);
  logic [LANES-1:0] first;

  // A lane is the first holder of its word when no lower active lane reads it.
  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      first[i] = active[i];
      for (int j = 0; j < i; j++) begin
        if (active[j] && keys[j] == keys[i]) first[i] = 1'b0;
      end
    end
  end

  // Distinct words per bank, maximum over banks.
  always_comb begin
    int best;
    best = 0;
    for (int b = 0; b < BANKS; b++) begin
      int cnt;
      cnt = 0;
      for (int i = 0; i < LANES; i++) begin
        if (first[i] && keys[i][BW-1:0] == BW'(b)) cnt = cnt + 1;
      end
      if (cnt > best) best = cnt;
    end
    passes = CW'(best);
  end
endmodule

// File: rtl/bca_pass_pick.sv
module bca_pass_pick #(
  parameter int unsigned LANES = 32,
  parameter int unsigned BANKS = 32,
  parameter int unsigned AW    = 16,
  localparam int unsigned BW   = $clog2(BANKS),
  localparam int unsigned RW   = AW - BW
) (
  input  logic [LANES-1:0]         pending,
  input  logic [LANES-1:0][AW-1:0] keys,
  output logic [LANES-1:0]         grant,
  output logic [BANKS-1:0]         bank_en,
  output logic [BANKS-1:0][RW-1:0] bank_row
);
  logic [BANKS-1:0][AW-1:0] sel_key;

  // Each bank takes the word of its lowest-numbered pending lane.
  always_comb begin
    for (int b = 0; b < BANKS; b++) begin
      sel_key[b] = '0;
      bank_en[b] = 1'b0;
      for (int i = LANES - 1; i >= 0; i--) begin
        if (pending[i] && keys[i][BW-1:0] == BW'(b)) begin
          sel_key[b] = keys[i];
          bank_en[b] = 1'b1;
        end
      end
      bank_row[b] = sel_key[b][AW-1:BW];
    end
  end

  // Every pending lane reading its bank's chosen word rides along.
  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      grant[i] = pending[i] && (keys[i] == sel_key[keys[i][BW-1:0]]);
    end
  end
endmodule

// File: rtl/bank_conflict_arb.sv
module bank_conflict_arb
  import bca_pkg::*;
#(
  parameter int unsigned LANES = BCA_LANES,
  parameter int unsigned BANKS = BCA_BANKS,
  parameter int unsigned AW    = BCA_AW,
  localparam int unsigned BW   = $clog2(BANKS),
  localparam int unsigned RW   = AW - BW,
  localparam int unsigned CW   = $clog2(LANES + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  wide_mode,
  input  logic [LANES-1:0]      req_active,
  input  logic [LANES*AW-1:0]   req_addr,
  output logic                  acc_valid,
  output logic [CW-1:0]         acc_passes,
  output logic                  pass_valid,
  output logic                  pass_last,
  output logic [LANES-1:0]      pass_grant,
  output logic [BANKS-1:0]      pass_bank_en,
  output logic [BANKS*RW-1:0]   pass_bank_row
);
  logic [LANES-1:0][AW-1:0] key_in;
  logic [LANES-1:0][AW-1:0] key_q;
  logic [LANES-1:0]         pending_q;
  logic                     busy_q;
  logic [CW-1:0]            need;
  logic [LANES-1:0]         pick_grant;
  logic [BANKS-1:0]         pick_en;
  logic [BANKS-1:0][RW-1:0] pick_row;
  logic [BANKS-1:0][RW-1:0] row_q;
  logic [LANES-1:0]         remain;

  // Word key per lane: 32-bit index, or 64-bit index in wide mode.
  for (genvar g = 0; g < LANES; g++) begin : g_key
    logic [AW-1:0] a;
    assign a = req_addr[g*AW +: AW];
    assign key_in[g] = (map_mode_e'(wide_mode) == MAP_WIDE) ? {1'b0, a[AW-1:1]} : a;
  end

  bca_pass_count #(.LANES(LANES), .BANKS(BANKS), .AW(AW)) u_count (
    .active (req_active),
    .keys   (key_in),
    .passes (need)
  );

  bca_pass_pick #(.LANES(LANES), .BANKS(BANKS), .AW(AW)) u_pick (
    .pending  (pending_q),
    .keys     (key_q),
    .grant    (pick_grant),
    .bank_en  (pick_en),
    .bank_row (pick_row)
  );

  assign remain    = pending_q & ~pick_grant;
  assign req_ready = !busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q       <= 1'b0;
      pending_q    <= '0;
      key_q        <= '0;
      acc_valid    <= 1'b0;
      acc_passes   <= '0;
      pass_valid   <= 1'b0;
      pass_last    <= 1'b0;
      pass_grant   <= '0;
      pass_bank_en <= '0;
      row_q        <= '0;
    end else begin
      acc_valid    <= 1'b0;
      pass_valid   <= 1'b0;
      pass_last    <= 1'b0;
      pass_grant   <= '0;
      pass_bank_en <= '0;
      if (!busy_q && req_valid) begin
        pending_q  <= req_active;
        key_q      <= key_in;
        acc_valid  <= 1'b1;
        acc_passes <= need;
        busy_q     <= (need != '0);
      end else if (busy_q) begin
        pass_valid   <= 1'b1;
        pass_grant   <= pick_grant;
        pass_bank_en <= pick_en;
        row_q        <= pick_row;
        pending_q    <= remain;
        if (remain == '0) begin
          busy_q    <= 1'b0;
          pass_last <= 1'b1;
        end
      end
    end
  end

  assign pass_bank_row = row_q;
endmodule

// File: rtl/bank_conflict_arb_chk.sv
module bank_conflict_arb_chk #(
  parameter int unsigned LANES = 32,
  parameter int unsigned CW    = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             req_ready,
  input logic             acc_valid,
  input logic [CW-1:0]    acc_passes,
  input logic             pass_valid,
  input logic             pass_last,
  input logic [LANES-1:0] pass_grant
);
  logic [CW-1:0] seen_q;
  logic [CW-1:0] want_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q <= '0;
      want_q <= '0;
    end else if (acc_valid) begin
      seen_q <= '0;
      want_q <= acc_passes;
    end else if (pass_valid) begin
      seen_q <= seen_q + 1'b1;
    end
  end

  p_count_match_r7: assert property (@(posedge clk) disable iff (rst)
    pass_last |-> (seen_q + 1'b1 == want_q));
  p_last_in_pass_r8: assert property (@(posedge clk) disable iff (rst)
    pass_last |-> pass_valid);
  p_grant_nonempty_r8: assert property (@(posedge clk) disable iff (rst)
    pass_valid |-> (pass_grant != '0));
  p_grant_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !pass_valid |-> (pass_grant == '0));
  p_stall_r10: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_passes != '0) |-> !req_ready);
  p_release_r10: assert property (@(posedge clk) disable iff (rst)
    pass_last |-> req_ready);
  p_empty_load_r11: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_passes == '0) |=> (req_ready && !pass_valid));
endmodule

bind bank_conflict_arb bank_conflict_arb_chk #(.LANES(LANES), .CW(CW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_ready  (req_ready),
  .acc_valid  (acc_valid),
  .acc_passes (acc_passes),
  .pass_valid (pass_valid),
  .pass_last  (pass_last),
  .pass_grant (pass_grant)
);

// File: tb/bank_conflict_arb_test.sv
module bank_conflict_arb_test;
  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          wide_mode = 1'b0;
  logic [31:0]   req_active = '0;
  logic [511:0]  req_addr = '0;
  logic          acc_valid;
  logic [5:0]    acc_passes;
  logic          pass_valid;
  logic          pass_last;
  logic [31:0]   pass_grant;
  logic [31:0]   pass_bank_en;
  logic [351:0]  pass_bank_row;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [31:0] first_grant;
  int          first_row0;
  logic [15:0] la [32];

  always #5 clk = ~clk;

  bank_conflict_arb uut (.*);

  // wide, stride, base, mask, expected passes
  localparam int NV = 16;
  localparam logic [72:0] VEC [NV] = '{
    {1'b0, 16'd1,    16'd0,   32'hFFFFFFFF, 8'd1},   // R4
    {1'b0, 16'd3,    16'd0,   32'hFFFFFFFF, 8'd1},   // R12
    {1'b0, 16'd2,    16'd0,   32'hFFFFFFFF, 8'd2},   // R7
    {1'b0, 16'd32,   16'd0,   32'hFFFFFFFF, 8'd32},  // R7
    {1'b0, 16'd0,    16'd100, 32'hFFFFFFFF, 8'd1},   // R5
    {1'b1, 16'd1,    16'd0,   32'hFFFFFFFF, 8'd1},   // R6
    {1'b1, 16'd2,    16'd0,   32'hFFFFFFFF, 8'd1},   // R3
    {1'b1, 16'd4,    16'd0,   32'hFFFFFFFF, 8'd2},   // R3
    {1'b0, 16'd1,    16'd0,   32'h00000000, 8'd0},   // R11
    {1'b0, 16'd32,   16'd0,   32'h0000000F, 8'd4},   // R7
    {1'b0, 16'd16,   16'd0,   32'hFFFFFFFF, 8'd16},  // R7
    {1'b1, 16'd64,   16'd0,   32'hFFFFFFFF, 8'd32},  // R3
    {1'b0, 16'd1,    16'd5,   32'hFFFFFFFF, 8'd1},   // R4 unaligned
    {1'b0, 16'hFFE0, 16'd992, 32'hFFFFFFFF, 8'd32},  // R9
    {1'b0, 16'd5,    16'd7,   32'hAAAA5555, 8'd1},   // R12
    {1'b1, 16'd0,    16'd40,  32'hFFFFFFFF, 8'd1}    // R5 wide
  };

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic run_load(input logic wm, input int stride, input int base,
                          input logic [31:0] mask, input int expn, input bit poke);
    logic [31:0] granted;
    int npass;
    bit saw_last;
    granted = '0;
    npass = 0;
    saw_last = 0;
    first_grant = '0;
    first_row0 = -1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R10 ready before load", int'(req_ready), 1);
    wide_mode = wm;
    req_active = mask;
    for (int l = 0; l < 32; l++) begin
      la[l] = 16'(base + l * stride);
      req_addr[l*16 +: 16] = la[l];
    end
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(acc_valid && acc_passes == 6'(expn), "R7 pass count", int'(acc_passes), expn);
    chk(!pass_valid, "R7 first pass one cycle later", int'(pass_valid), 0);
    if (poke) begin
      req_valid = 1'b1;
      req_active = '1;
      for (int l = 0; l < 32; l++) req_addr[l*16 +: 16] = 16'(l * 7 + 3);
    end
    for (int c = 0; c < expn + 3; c++) begin
      @(negedge clk);
      if (poke && !pass_last)
        chk(!req_ready && !acc_valid, "R10 busy ignores load", int'(acc_valid), 0);
      if (pass_valid) begin
        int errs;
        errs = 0;
        if (npass == 0) begin
          first_grant = pass_grant;
          first_row0 = int'(pass_bank_row[10:0]);
        end
        npass++;
        for (int l = 0; l < 32; l++) begin
          if (pass_grant[l]) begin
            logic [15:0] k;
            k = wm ? {1'b0, la[l][15:1]} : la[l];
            if (!pass_bank_en[k[4:0]]) errs++;
            if (pass_bank_row[int'(k[4:0])*11 +: 11] != k[15:5]) errs++;
            if (granted[l] || !mask[l]) errs++;
          end
        end
        granted = granted | pass_grant;
        chk(errs == 0, wm ? "R3 wide map and grant" : "R2 narrow map and grant", errs, 0);
      end
      if (pass_last) begin
        saw_last = 1;
        req_valid = 1'b0;
        break;
      end
    end
    req_valid = 1'b0;
    chk(npass == expn && saw_last == (expn != 0), "R8 pass run length", npass, expn);
    chk(granted == mask, "R8 every active lane once", int'(granted), int'(mask));
    chk(req_ready == 1'b1, "R10 ready after last", int'(req_ready), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(req_ready && !acc_valid && !pass_valid && !pass_last && pass_grant == '0,
        "R1 reset state", int'(pass_valid), 0);

    for (int v = 0; v < NV; v++) begin
      run_load(VEC[v][72], int'($signed(VEC[v][71:56])), int'(VEC[v][55:40]),
               VEC[v][39:8], int'(VEC[v][7:0]), 1'b0);
      if (v == 3) chk(first_grant == 32'h1, "R9 lowest lane first", int'(first_grant), 1);
      if (v == 13) chk(first_grant == 32'h1 && first_row0 == 31,
                       "R9 lowest lane not lowest address", first_row0, 31);
      if (v == 4) chk(first_grant == 32'hFFFFFFFF, "R5 broadcast one pass", int'(first_grant), -1);
    end

    // R10: load held high while busy must be ignored
    run_load(1'b0, 32, 0, 32'hFFFFFFFF, 32, 1'b1);

    // R1: reset in the middle of a run
    @(negedge clk);
    wide_mode = 1'b0;
    req_active = '1;
    for (int l = 0; l < 32; l++) req_addr[l*16 +: 16] = 16'(l * 32);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(req_ready && !acc_valid && !pass_valid && !pass_last && pass_grant == '0,
        "R1 reset mid run", int'(req_ready), 1);
    run_load(1'b1, 1, 0, 32'h0F0F0F0F, 1, 1'b0);   // R6 after reset

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      chk(1'b0, "R8 watchdog expired", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule